// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display Data Transmitter

This block streams bytes out of a monitor's display-data port with no host-driven clock. While its mode-enable bit is set, every rising edge of the monitor's vertical-sync signal moves one bit onto the serial data output. There is no addressing phase: the stream starts at the first sync edge after the mode is switched on and runs for as long as the mode stays on.

Bytes come from a CPU-written holding register. When a new frame begins, the shifter takes the holding register's contents, and a transmit-empty flag asks the CPU for the next byte. A frame is the byte, most significant bit first, followed by a trailing high bit. If the CPU has not written again by the next frame, the same byte goes out once more. While the mode is on, the read/write direction status reads as 1. While it is off, the direction bit supplied by the addressed-mode logic passes through unchanged.

The sync input is asynchronous. A flop chain brings it into the system clock domain, and a rising-edge detector follows the chain.

Top module: `ddc1_vsync_tx`

## Requirements
- R1: After reset the mode is off, `sda_out` is 1, `tx_empty` is 1, and `rw_status` equals `normal_rw_in`.
- R2: While the mode is off, rising edges on `vsync_in` have no effect and `sda_out` stays 1.
- R3: While the mode is on, each rising edge of `vsync_in` puts exactly one new bit on `sda_out`. A frame is DATA_W data bits, most significant first, followed by TRAIL_BITS bits of value 1. Between sync edges `sda_out` holds its value.
- R4: No address phase is used. The first sync edge after the mode is enabled, and the first edge of every later frame, loads the holding register into the shifter, drives its most significant bit, and sets `tx_empty` to 1.
- R5: A one-cycle pulse on `data_wr` stores `data_in` and clears `tx_empty` on the next clock edge. If a reload happens in the same cycle, the write still wins.
- R6: If no write happens before a frame starts, the previously loaded byte is sent again.
- R7: A `ctrl_wr` pulse with `ctrl_en`=1 turns the mode on. From the next clock edge `rw_status` reads 1 while the mode is on.
- R8: A `ctrl_wr` pulse with `ctrl_en`=0 turns the mode off. From the next clock edge `sda_out` is 1, and the bit counter is reset, so the next enabled frame starts again at the most significant bit.
- R9: A rising edge on `vsync_in` changes `sda_out` on the (SYNC_STAGES+1)-th rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Asynchronous vertical-sync signal used as the bit clock |
| ctrl_wr | input | 1 | Write strobe for the mode-enable bit |
| ctrl_en | input | 1 | Value written to the mode-enable bit |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | DATA_W | Byte written to the holding register |
| normal_rw_in | input | 1 | Direction bit from the addressed-mode logic |
| sda_out | output | 1 | Serial data output, 1 when released |
| tx_empty | output | 1 | Holding register has been consumed |
| rw_status | output | 1 | Read/write direction status, forced to 1 in this mode |

## Verification
The bench uses the defaults DATA_W=8, TRAIL_BITS=1 and SYNC_STAGES=2, so a frame is nine sync edges and a sync edge reaches the output on the third clock edge. With eight data bits, bytes such as 0x5A and 0xC3 show the bit order, and a first bit of 0 makes the output latency visible against the idle-high line. The single trailing bit makes it possible to observe the frame boundary, the repeated byte and a restart after a mid-frame disable.

// File: rtl/ddc1_tx_pkg.sv
package ddc1_tx_pkg;

   // Position of the shifter inside a frame
   typedef enum logic [1:0] {
      PH_LOAD  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_TRAIL = 2'd2
   } tx_phase_e;

endpackage

// File: rtl/ddc1_sync_edge.sv
module ddc1_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ddc1_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ddc1_tx_hold.sv
module ddc1_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              take_i,
   output logic [DATA_W-1:0] data_o,
   output logic              empty_o
);

   logic [DATA_W-1:0] hold_q;
   logic              empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else if (wr_i) hold_q <= data_i;
   end

   // a write in the same cycle as a take wins: the new byte is still pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      empty_q <= 1'b1;
      else if (wr_i)   empty_q <= 1'b0;
      else if (take_i) empty_q <= 1'b1;
   end

   assign data_o  = hold_q;
   assign empty_o = empty_q;

endmodule

// File: rtl/ddc1_tx_shift.sv
module ddc1_tx_shift
   import ddc1_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int TRAIL_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] load_i,
   output logic              take_o,
   output logic              sda_o
);

   localparam int FRAME_LEN = DATA_W + TRAIL_BITS;
   localparam int CNT_W     = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ddc1_tx_shift: DATA_W must be at least 2");
      end
      if (TRAIL_BITS < 0) begin : g_bad_trail
         $error("ddc1_tx_shift: TRAIL_BITS must not be negative");
      end
   endgenerate

   logic [CNT_W-1:0]  pos_q;
   logic [DATA_W-1:0] shreg_q;
   logic              sda_q;
   tx_phase_e         phase;

   always_comb begin
      if (pos_q == '0)           phase = PH_LOAD;
      else if (pos_q < DATA_END) phase = PH_SHIFT;
      else                       phase = PH_TRAIL;
   end

   assign take_o = en_i & step_i & (phase == PH_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         shreg_q <= '0;
         sda_q   <= 1'b1;
      end else if (!en_i) begin
         pos_q   <= '0;
         sda_q   <= 1'b1;
      end else if (step_i) begin
         pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
         unique case (phase)
            PH_LOAD: begin
               sda_q   <= load_i[DATA_W-1];
               shreg_q <= {load_i[DATA_W-2:0], 1'b0};
            end
            PH_SHIFT: begin
               sda_q   <= shreg_q[DATA_W-1];
               shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            end
            default: sda_q <= 1'b1;
         endcase
      end
   end

   // released high the moment the mode bit drops
   assign sda_o = en_i ? sda_q : 1'b1;

endmodule

// File: rtl/ddc1_vsync_tx.sv
module ddc1_vsync_tx #(
   parameter int DATA_W      = 8,
   parameter int TRAIL_BITS  = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              ctrl_wr,
   input  logic              ctrl_en,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              normal_rw_in,
   output logic              sda_out,
   output logic              tx_empty,
   output logic              rw_status
);

   logic              en_q;
   logic              vs_rise;
   logic              take;
   logic [DATA_W-1:0] hold_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (ctrl_wr) en_q <= ctrl_en;
   end

   ddc1_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (vsync_in),
      .rise_o   (vs_rise)
   );

   ddc1_tx_hold #(.DATA_W(DATA_W)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (data_wr),
      .data_i  (data_in),
      .take_i  (take),
      .data_o  (hold_data),
      .empty_o (tx_empty)
   );

   ddc1_tx_shift #(.DATA_W(DATA_W), .TRAIL_BITS(TRAIL_BITS)) i_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_q),
      .step_i (vs_rise),
      .load_i (hold_data),
      .take_o (take),
      .sda_o  (sda_out)
   );

   assign rw_status = en_q | normal_rw_in;

endmodule

// File: rtl/ddc1_vsync_tx_chk.sv
module ddc1_vsync_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic ctrl_wr,
   input logic ctrl_en,
   input logic data_wr,
   input logic sda_out,
   input logic tx_empty,
   input logic rw_status,
   input logic vs_rise,
   input logic en_q
);

   // R7
   mode_on_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_en) |=> rw_status);

   // R8
   mode_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !ctrl_en) |=> sda_out);

   // R5
   write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !tx_empty);

   // R4
   empty_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(vs_rise));

   // R3
   hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q) && !$past(vs_rise)) |-> $stable(sda_out));

endmodule

bind ddc1_vsync_tx ddc1_vsync_tx_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_wr   (ctrl_wr),
   .ctrl_en   (ctrl_en),
   .data_wr   (data_wr),
   .sda_out   (sda_out),
   .tx_empty  (tx_empty),
   .rw_status (rw_status),
   .vs_rise   (vs_rise),
   .en_q      (en_q)
);

// File: tb/test_ddc1_vsync_tx.sv
module test_ddc1_vsync_tx;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vsync_in = 1'b0;
   logic          ctrl_wr = 1'b0;
   logic          ctrl_en = 1'b0;
   logic          data_wr = 1'b0;
   logic [DW-1:0] data_in = '0;
   logic          normal_rw_in = 1'b0;
   logic          sda_out;
   logic          tx_empty;
   logic          rw_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   bit exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ddc1_vsync_tx i_ddc1_vsync_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .vsync_in     (vsync_in),
      .ctrl_wr      (ctrl_wr),
      .ctrl_en      (ctrl_en),
      .data_wr      (data_wr),
      .data_in      (data_in),
      .normal_rw_in (normal_rw_in),
      .sda_out      (sda_out),
      .tx_empty     (tx_empty),
      .rw_status    (rw_status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: expected frame of one byte, MSB first, then the high trailing bit
   task automatic push_frame(input logic [DW-1:0] b);
      for (int i = DW-1; i >= 0; i--) exp_q.push_back(b[i]);
      exp_q.push_back(1'b1);
   endtask

   task automatic write_data(input logic [DW-1:0] b);
      data_in = b; data_wr = 1'b1;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic write_ctrl(input bit v);
      ctrl_en = v; ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   // one sync pulse; the monitor side pops the expected bit and compares
   task automatic pulse(input string tag);
      bit e;
      logic prev;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
      prev = sda_out;
      vsync_in = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (e != prev) check(sda_out == prev, "R9 early change", sda_out, prev);
      @(posedge clk);
      @(negedge clk);
      check(sda_out == e, tag, sda_out, e);
      vsync_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sda_out == 1'b1, "R1 sda idle", sda_out, 1);
      check(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
      check(rw_status == 1'b0, "R1 rw passthrough 0", rw_status, 0);
      normal_rw_in = 1'b1;
      #1 check(rw_status == 1'b1, "R1 rw passthrough 1", rw_status, 1);
      normal_rw_in = 1'b0;

      // R2: disabled, edges ignored
      repeat (3) pulse("R2 disabled sda");
      check(tx_empty == 1'b1, "R2 empty untouched", tx_empty, 1);

      write_data(8'h5A);
      check(tx_empty == 1'b0, "R5 write clears empty", tx_empty, 0);
      write_ctrl(1'b1);
      check(rw_status == 1'b1, "R7 rw forced", rw_status, 1);

      // R4: first edge after enable starts the byte
      push_frame(8'h5A);
      pulse("R4 first bit");
      check(tx_empty == 1'b1, "R4 empty on load", tx_empty, 1);
      repeat (3) pulse("R3 frame 5A");
      write_data(8'h3C);
      check(tx_empty == 1'b0, "R5 refill", tx_empty, 0);
      repeat (5) pulse("R3 frame 5A tail");

      push_frame(8'h3C);
      pulse("R3 frame 3C");
      check(tx_empty == 1'b1, "R4 empty second frame", tx_empty, 1);
      repeat (8) pulse("R3 frame 3C");

      // R6: no refill, byte repeats
      push_frame(8'h3C);
      repeat (9) pulse("R6 repeat 3C");
      check(tx_empty == 1'b1, "R6 empty stays", tx_empty, 1);

      // R8: disable mid frame
      write_data(8'hC3);
      push_frame(8'hC3);
      repeat (4) pulse("R3 frame C3 head");
      check(sda_out == 1'b0, "R3 C3 bit4", sda_out, 0);
      exp_q.delete();
      write_ctrl(1'b0);
      check(sda_out == 1'b1, "R8 released", sda_out, 1);
      check(rw_status == 1'b0, "R8 rw passthrough", rw_status, 0);
      repeat (2) pulse("R2 disabled after stop");
      write_ctrl(1'b1);
      push_frame(8'hC3);
      repeat (9) pulse("R8 restart at MSB");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule